// File: doc/BRIEF.md
# HDLC Receive Address Filter

This block sits on a D-channel receive path behind a deframer that has already removed flags and stuffed bits. It sees one frame byte per valid beat, with markers on the first and last beat of each frame. It compares the leading one or two address bytes against a set of programmable patterns and a fixed group pattern. For every frame it evaluates, it reports exactly one verdict, accepted or discarded, as a single-cycle pulse.

Two programmable values and one group value exist for each address byte. The high (first) byte group pattern is FC hex, with bit 1 ignored so that the command/response bit has no effect. The low byte group pattern is FF hex. A two-bit mode selects the comparison: pass everything, compare the high byte only, or compare the low byte only. A per-byte method bit selects between two kinds of match: a plain equality check, or a masked check. A length input says whether the address field is one byte or two. An enable input decides whether frames are evaluated at all. All of these settings are captured on the first beat of a frame.

Top module: `hdlc_addr_filter`

## Requirements
- R1: When `rx_enable` is 0 on the start beat of a frame, that frame produces neither a `frame_ok` nor a `frame_drop` pulse.
- R2: With mode code 2'b00 (pass all) or the spare code 2'b11, every evaluated frame is accepted, whatever its bytes are, including a one-byte frame.
- R3: With mode 2'b01 and a two-byte address (`addr_two`=1), the first byte decides the verdict through the high-byte match, and the second byte has no effect.
- R4: With mode 2'b01 and a one-byte address (`addr_two`=0), no comparison is made and the frame is accepted.
- R5: With mode 2'b10, the low-byte match is applied to the second byte when `addr_two`=1, or to the first byte when `addr_two`=0. The other byte has no effect.
- R6: High-byte match. With `hi_mask_mode`=0, the byte matches if it equals `hi_val_a` or `hi_val_b`. With `hi_mask_mode`=1, it matches if it equals `hi_val_a` in every bit where `hi_val_b` is 0. In either method the byte also matches if it is FC or FE hex.
- R7: Low-byte match. With `lo_mask_mode`=0, the byte matches if it equals `lo_val_a` or `lo_val_b`. With `lo_mask_mode`=1, it matches if it equals `lo_val_a` in every bit where `lo_val_b` is 0. In either method the byte also matches if it is FF hex.
- R8: A frame whose end beat arrives before every address byte that the mode needs has been seen is discarded.
- R9: Mode, length, method bits, address values and the enable are taken on the start beat. A change made later in the frame does not affect that frame's verdict.
- R10: The verdict is a one-cycle pulse on exactly one of `frame_ok` or `frame_drop`. It appears in the cycle after the end beat, and never at any other time. Both outputs are 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_enable | input | 1 | Evaluate frames when 1 |
| addr_two | input | 1 | 1: two-byte address field, 0: one byte |
| mode | input | 2 | 00 pass all, 01 high byte, 10 low byte, 11 pass all |
| hi_mask_mode | input | 1 | High-byte method: 0 equality, 1 masked |
| lo_mask_mode | input | 1 | Low-byte method: 0 equality, 1 masked |
| hi_val_a | input | W | First high-byte value |
| hi_val_b | input | W | Second high-byte value, or mask when masked |
| lo_val_a | input | W | First low-byte value |
| lo_val_b | input | W | Second low-byte value, or mask when masked |
| in_valid | input | 1 | Byte beat valid |
| in_data | input | W | Frame byte |
| in_sof | input | 1 | Beat is the first byte of a frame |
| in_eof | input | 1 | Beat is the last byte of a frame |
| frame_ok | output | 1 | Accepted-frame pulse |
| frame_drop | output | 1 | Discarded-frame pulse |

## Verification
The compared byte is swept through all 256 values in each mode that compares, under both method bits, while the byte that is not compared is held at values that would fail the match. This separates equality from masked matching, checks the group patterns and the ignored command/response bit, and shows that each byte goes to the right comparator. Frames shorter than the address field show the early-end rule. A setting changed in the middle of a frame, in both directions, shows that the values are captured at the start beat. A frame with the enable cleared shows that no verdict is produced at all.

// File: rtl/hdlc_af_pkg.sv
package hdlc_af_pkg;

   typedef enum logic [1:0] {
      AF_PASS_ALL  = 2'b00,
      AF_HIGH_ONLY = 2'b01,
      AF_LOW_ONLY  = 2'b10,
      AF_SPARE     = 2'b11
   } af_mode_e;

   typedef struct packed {
      logic     two;
      af_mode_e mode;
      logic     hi_mask;
      logic     lo_mask;
   } af_ctl_t;

endpackage

// File: rtl/hdlc_af_match.sv
module hdlc_af_match #(
   parameter int             W        = 8,
   parameter logic [W-1:0]   GROUP    = '1,
   parameter logic [W-1:0]   GROUP_DC = '0
) (
   input  logic         use_mask,
   input  logic [W-1:0] val_a,
   input  logic [W-1:0] val_b,
   input  logic [W-1:0] data,
   output logic         hit
);

   logic prog_hit;
   logic grp_hit;

   if (W < 2) begin : g_bad_width
      $error("hdlc_af_match: W must be at least 2");
   end

   always_comb begin
      if (use_mask) prog_hit = (((data ^ val_a) & ~val_b) == '0);
      else          prog_hit = (data == val_a) || (data == val_b);
   end

   if (GROUP_DC == '0) begin : g_exact
      assign grp_hit = (data == GROUP);
   end else begin : g_dont_care
      assign grp_hit = (((data ^ GROUP) & ~GROUP_DC) == '0);
   end

   assign hit = prog_hit | grp_hit;

endmodule

// File: rtl/hdlc_af_ctrl.sv
module hdlc_af_ctrl
   import hdlc_af_pkg::*;
#(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_enable,
   input  af_ctl_t      ctl_live,
   input  logic [W-1:0] hi_a_live,
   input  logic [W-1:0] hi_b_live,
   input  logic [W-1:0] lo_a_live,
   input  logic [W-1:0] lo_b_live,
   input  logic         in_valid,
   input  logic         in_sof,
   input  logic         in_eof,
   input  logic         hi_hit,
   input  logic         lo_hit,
   output af_ctl_t      ctl_eff,
   output logic [W-1:0] hi_a_eff,
   output logic [W-1:0] hi_b_eff,
   output logic [W-1:0] lo_a_eff,
   output logic [W-1:0] lo_b_eff,
   output logic         frame_ok,
   output logic         frame_drop
);

   localparam int MAX_ADDR = 2;
   localparam int CNT_W    = $clog2(MAX_ADDR + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_ADDR);

   af_ctl_t          ctl_q;
   logic [W-1:0]     hi_a_q, hi_b_q, lo_a_q, lo_b_q;
   logic             act_q;
   logic             ok_q;
   logic [CNT_W-1:0] cnt_q;

   logic             beat;
   logic [CNT_W-1:0] pos;
   logic [CNT_W-1:0] cnt_nxt;
   logic [CNT_W-1:0] need;
   logic             chk_hi, chk_lo;
   logic             ok_nxt;
   logic             verdict;

   assign ctl_eff  = in_sof ? ctl_live  : ctl_q;
   assign hi_a_eff = in_sof ? hi_a_live : hi_a_q;
   assign hi_b_eff = in_sof ? hi_b_live : hi_b_q;
   assign lo_a_eff = in_sof ? lo_a_live : lo_a_q;
   assign lo_b_eff = in_sof ? lo_b_live : lo_b_q;

   assign beat    = in_valid && (in_sof ? rx_enable : act_q);
   assign pos     = in_sof ? '0 : cnt_q;
   assign cnt_nxt = (pos == CNT_MAX) ? CNT_MAX : pos + 1'b1;

   always_comb begin
      need   = '0;
      chk_hi = 1'b0;
      chk_lo = 1'b0;
      unique case (ctl_eff.mode)
         AF_HIGH_ONLY: begin
            need   = ctl_eff.two ? CNT_W'(1) : '0;
            chk_hi = ctl_eff.two && (pos == '0);
         end
         AF_LOW_ONLY: begin
            need   = ctl_eff.two ? CNT_W'(2) : CNT_W'(1);
            chk_lo = ctl_eff.two ? (pos == CNT_W'(1)) : (pos == '0);
         end
         default: begin
            need = '0;
         end
      endcase
   end

   assign ok_nxt  = (in_sof ? 1'b1 : ok_q) & (~chk_hi | hi_hit) & (~chk_lo | lo_hit);
   assign verdict = ok_nxt && (cnt_nxt >= need);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ctl_q      <= '0;
         hi_a_q     <= '0;
         hi_b_q     <= '0;
         lo_a_q     <= '0;
         lo_b_q     <= '0;
         act_q      <= 1'b0;
         ok_q       <= 1'b0;
         cnt_q      <= '0;
         frame_ok   <= 1'b0;
         frame_drop <= 1'b0;
      end else begin
         frame_ok   <= beat && in_eof && verdict;
         frame_drop <= beat && in_eof && !verdict;
         if (in_valid && in_sof) begin
            act_q  <= rx_enable && !in_eof;
            ctl_q  <= ctl_live;
            hi_a_q <= hi_a_live;
            hi_b_q <= hi_b_live;
            lo_a_q <= lo_a_live;
            lo_b_q <= lo_b_live;
         end else if (beat && in_eof) begin
            act_q  <= 1'b0;
         end
         if (beat) begin
            cnt_q <= cnt_nxt;
            ok_q  <= ok_nxt;
         end
      end
   end

   AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && !rx_enable) |=> (!frame_ok && !frame_drop)); // R1

   AST_PASS_ALL_ACCEPTS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && in_eof && rx_enable && ctl_live.mode == AF_PASS_ALL) |=> frame_ok); // R2

   AST_SHORT_FRAME_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_sof && in_eof && rx_enable && ctl_live.two && ctl_live.mode == AF_LOW_ONLY) |=> frame_drop); // R8

   AST_ONE_VERDICT: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_ok && frame_drop)); // R10

   AST_PULSE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
      !(in_valid && in_eof) |=> (!frame_ok && !frame_drop)); // R10

endmodule

// File: rtl/hdlc_addr_filter.sv
module hdlc_addr_filter
   import hdlc_af_pkg::*;
#(
   parameter int           W           = 8,
   parameter logic [W-1:0] HI_GROUP    = W'(8'hFC),
   parameter logic [W-1:0] HI_GROUP_DC = W'(8'h02),
   parameter logic [W-1:0] LO_GROUP    = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         rx_enable,
   input  logic         addr_two,
   input  logic [1:0]   mode,
   input  logic         hi_mask_mode,
   input  logic         lo_mask_mode,
   input  logic [W-1:0] hi_val_a,
   input  logic [W-1:0] hi_val_b,
   input  logic [W-1:0] lo_val_a,
   input  logic [W-1:0] lo_val_b,
   input  logic         in_valid,
   input  logic [W-1:0] in_data,
   input  logic         in_sof,
   input  logic         in_eof,
   output logic         frame_ok,
   output logic         frame_drop
);

   if (W < 2) begin : g_bad_width
      $error("hdlc_addr_filter: W must be at least 2");
   end

   af_ctl_t      ctl_live, ctl_eff;
   logic [W-1:0] hi_a_eff, hi_b_eff, lo_a_eff, lo_b_eff;
   logic         hi_hit, lo_hit;

   assign ctl_live = '{two: addr_two, mode: af_mode_e'(mode),
                       hi_mask: hi_mask_mode, lo_mask: lo_mask_mode};

   hdlc_af_match #(.W(W), .GROUP(HI_GROUP), .GROUP_DC(HI_GROUP_DC)) hi_match_i (
      .use_mask (ctl_eff.hi_mask),
      .val_a    (hi_a_eff),
      .val_b    (hi_b_eff),
      .data     (in_data),
      .hit      (hi_hit)
   );

   hdlc_af_match #(.W(W), .GROUP(LO_GROUP), .GROUP_DC('0)) lo_match_i (
      .use_mask (ctl_eff.lo_mask),
      .val_a    (lo_a_eff),
      .val_b    (lo_b_eff),
      .data     (in_data),
      .hit      (lo_hit)
   );

   hdlc_af_ctrl #(.W(W)) ctrl_i (
      .clk        (clk),
      .rst_n      (rst_n),
      .rx_enable  (rx_enable),
      .ctl_live   (ctl_live),
      .hi_a_live  (hi_val_a),
      .hi_b_live  (hi_val_b),
      .lo_a_live  (lo_val_a),
      .lo_b_live  (lo_val_b),
      .in_valid   (in_valid),
      .in_sof     (in_sof),
      .in_eof     (in_eof),
      .hi_hit     (hi_hit),
      .lo_hit     (lo_hit),
      .ctl_eff    (ctl_eff),
      .hi_a_eff   (hi_a_eff),
      .hi_b_eff   (hi_b_eff),
      .lo_a_eff   (lo_a_eff),
      .lo_b_eff   (lo_b_eff),
      .frame_ok   (frame_ok),
      .frame_drop (frame_drop)
   );

endmodule

// File: tb/hdlc_addr_filter_tb_top.sv
module hdlc_addr_filter_tb_top;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       rx_enable = 1'b1;
   logic       addr_two = 1'b1;
   logic [1:0] mode = 2'b00;
   logic       hi_mask_mode = 1'b0;
   logic       lo_mask_mode = 1'b0;
   logic [7:0] hi_val_a = 8'h10;
   logic [7:0] hi_val_b = 8'h24;
   logic [7:0] lo_val_a = 8'h42;
   logic [7:0] lo_val_b = 8'h81;
   logic       in_valid = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic       in_sof = 1'b0;
   logic       in_eof = 1'b0;
   logic       frame_ok, frame_drop;

   int compared = 0;
   int mismatched = 0;
   bit finished = 1'b0;

   always #5 clk = ~clk;

   hdlc_addr_filter dut_i (
      .clk(clk), .rst_n(rst_n), .rx_enable(rx_enable), .addr_two(addr_two),
      .mode(mode), .hi_mask_mode(hi_mask_mode), .lo_mask_mode(lo_mask_mode),
      .hi_val_a(hi_val_a), .hi_val_b(hi_val_b), .lo_val_a(lo_val_a), .lo_val_b(lo_val_b),
      .in_valid(in_valid), .in_data(in_data), .in_sof(in_sof), .in_eof(in_eof),
      .frame_ok(frame_ok), .frame_drop(frame_drop)
   );

   function automatic bit hi_hit(input logic [7:0] b);
      bit p;
      p = hi_mask_mode ? (((b ^ hi_val_a) & ~hi_val_b) == 8'h00)
                       : (b == hi_val_a || b == hi_val_b);
      return p || ((b | 8'h02) == 8'hFE);
   endfunction

   function automatic bit lo_hit(input logic [7:0] b);
      bit p;
      p = lo_mask_mode ? (((b ^ lo_val_a) & ~lo_val_b) == 8'h00)
                       : (b == lo_val_a || b == lo_val_b);
      return p || (b == 8'hFF);
   endfunction

   // 0 = no pulse, 1 = accept, 2 = discard; uses settings present at call time
   function automatic int model(input int len, input logic [7:0] b0, input logic [7:0] b1);
      int need;
      bit ok;
      if (!rx_enable) return 0;
      need = 0;
      ok   = 1'b1;
      if (mode == 2'b01 && addr_two) begin
         need = 1; ok = hi_hit(b0);
      end else if (mode == 2'b10) begin
         need = addr_two ? 2 : 1;
         ok   = lo_hit(addr_two ? b1 : b0);
      end
      if (len < need) return 2;
      return ok ? 1 : 2;
   endfunction

   task automatic send(input int len, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input bit chg, input logic [7:0] new_la);
      for (int k = 0; k < len; k++) begin
         @(negedge clk);
         if (k == 1 && chg) lo_val_a = new_la;
         in_valid = 1'b1;
         in_sof   = (k == 0);
         in_eof   = (k == len - 1);
         in_data  = (k == 0) ? b0 : (k == 1) ? b1 : b2;
      end
      @(negedge clk);
      in_valid = 1'b0;
      in_sof   = 1'b0;
      in_eof   = 1'b0;
   endtask

   task automatic check(input int exp, input string req);
      logic [1:0] got, want;
      got  = {frame_drop, frame_ok};
      want = (exp == 1) ? 2'b01 : (exp == 2) ? 2'b10 : 2'b00;
      compared++;
      if (got != want) begin
         mismatched++;
         $display("FAIL %s: {drop,ok} actual=%b expected=%b", req, got, want);
      end
      @(negedge clk);
      compared++;
      if (frame_ok || frame_drop) begin
         mismatched++;
         $display("FAIL R10: pulse longer than one cycle actual={%b,%b} expected=00",
                  frame_drop, frame_ok);
      end
   endtask

   task automatic frame(input int len, input logic [7:0] b0, input logic [7:0] b1,
                        input string req);
      int e;
      e = model(len, b0, b1);
      send(len, b0, b1, 8'h5A, 1'b0, 8'h00);
      check(e, req);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      compared++;
      if (frame_ok || frame_drop) begin
         mismatched++;
         $display("FAIL R10: reset state actual={%b,%b} expected=00", frame_drop, frame_ok);
      end
      rst_n = 1'b1;
      @(negedge clk);

      // R2: pass all and spare code, including one-byte frames
      mode = 2'b00;
      frame(3, 8'h00, 8'h00, "R2");
      frame(1, 8'h33, 8'h00, "R2");
      mode = 2'b11;
      frame(3, 8'h01, 8'h02, "R2");
      frame(1, 8'h99, 8'h00, "R2");

      // R3/R6: high byte swept, second byte would fail any compare
      mode = 2'b01; addr_two = 1'b1;
      for (int m = 0; m < 2; m++) begin
         hi_mask_mode = m[0];
         for (int v = 0; v < 256; v++) frame(3, 8'(v), 8'h00, "R3_R6");
      end
      hi_mask_mode = 1'b0;
      frame(3, 8'h10, 8'h77, "R3");
      frame(3, 8'h11, 8'hFF, "R3");

      // R4: high-only with one-byte address
      addr_two = 1'b0;
      frame(2, 8'h00, 8'h00, "R4");
      frame(1, 8'h01, 8'h00, "R4");

      // R5/R7: low byte swept in both positions and both methods
      mode = 2'b10;
      for (int t = 0; t < 2; t++) begin
         addr_two = t[0];
         for (int m = 0; m < 2; m++) begin
            lo_mask_mode = m[0];
            for (int v = 0; v < 256; v++) begin
               if (addr_two) frame(3, 8'h00, 8'(v), "R5_R7");
               else          frame(2, 8'(v), 8'h00, "R5_R7");
            end
         end
      end
      lo_mask_mode = 1'b0;
      addr_two = 1'b1;
      frame(2, 8'h42, 8'h00, "R5");
      frame(2, 8'h00, 8'h42, "R5");

      // R8: frames shorter than the address field
      frame(1, 8'h42, 8'h00, "R8");
      mode = 2'b01;
      frame(1, 8'h10, 8'h00, "R3");

      // R9: settings captured at the start beat
      mode = 2'b10; addr_two = 1'b1; lo_val_a = 8'h42;
      send(2, 8'h00, 8'h55, 8'h00, 1'b1, 8'h55);
      check(2, "R9");
      lo_val_a = 8'h42;
      send(2, 8'h00, 8'h42, 8'h00, 1'b1, 8'h77);
      check(1, "R9");
      lo_val_a = 8'h42;

      // R1: disabled receiver gives no verdict
      rx_enable = 1'b0;
      mode = 2'b00;
      send(3, 8'h00, 8'h00, 8'h00, 1'b0, 8'h00);
      check(0, "R1");
      mode = 2'b10;
      send(1, 8'h42, 8'h00, 8'h00, 1'b0, 8'h00);
      check(0, "R1");
      rx_enable = 1'b1;
      frame(2, 8'h00, 8'h42, "R1");

      finished = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         compared++;
         mismatched++;
         $display("FAIL watchdog: run did not complete actual=hung expected=done");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
         $finish;
      end
   end

endmodule